// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects sixteen level-sensitive peripheral interrupt requests and one 4-bit encoded external level input. It picks the single most urgent request and presents its 4-bit urgency level and a 12-bit event code to the processor. Urgency comes from three 16-bit priority registers, each split into four 4-bit fields. A field is owned by one source or by a group of related sources. A field value of zero switches its sources off. Seven of the sources are further gated by a mask register, which has one address for setting bits and another for clearing them.

The outputs are registered and a new choice is made every cycle. A two-state machine tracks whether anything is being presented. In state `IDLE` the outputs are zero. The transition *raise* goes from `IDLE` to `ASSERT` when some candidate exists. In `ASSERT`, `irq_pend` is high, and the transition *retarget* (`ASSERT` to `ASSERT`) loads each new winner. The transition *drop* goes from `ASSERT` back to `IDLE` when no candidate is left. The transition *rest* (`IDLE` to `IDLE`) holds the zero outputs.

Source index, event code, priority field and mask bit:

| idx | source | code | field | mask bit |
|---|---|---|---|---|
| 0 | timer 0 | 0x400 | reg0 [3:0] | - |
| 1 | timer 1 | 0x420 | reg0 [7:4] | - |
| 2 | timer 2 underflow | 0x440 | reg0 [11:8] | - |
| 3 | timer 2 capture | 0x460 | reg0 [11:8] | - |
| 4 | watchdog | 0x560 | reg0 [15:12] | - |
| 5..8 | serial error, receive, transmit, transmit-end | 0x4E0, 0x500, 0x520, 0x540 | reg1 [3:0] | - |
| 9, 10 | extra timer 3, extra timer 4 | 0xB00, 0xB80 | reg2 [3:0] | 0, 1 |
| 11 | bus bridge error | 0xA00 | reg2 [7:4] | 2 |
| 12..15 | bridge DMA 0..3 | 0xA80, 0xA60, 0xA40, 0xA20 | reg2 [11:8] | 3..6 |

Top module: `pic_top`

## Requirements
- R1: After reset, `irq_pend`, `irq_level` and `irq_code` are 0. All three priority registers read 0. The mask reads 0xFFFFFFFF, meaning every gated source is masked.
- R2: A write to address 0, 1 or 2 loads `wr_data[15:0]` into priority register 0, 1 or 2. A read at the same address returns that value zero-extended to 32 bits. Field k of a register occupies bits [4k+3:4k].
- R3: A pending source whose priority field is 0 never wins and never raises `irq_pend`.
- R4: Each source maps to the code, field and mask bit given in the table above.
- R5: Sources in one group share one field but report their own distinct codes.
- R6: An external level n in 0..14 is a request with code 0x200 + 0x20*n and urgency 15-n. The value 15 is no request.
- R7: Writing address 3 sets every mask bit that is 1 in `wr_data`. Writing address 4 clears every mask bit that is 1 in `wr_data`. Reads at address 3 and 4 both return the mask. A set mask bit stops its source (mask bit b gates source 9+b).
- R8: Among candidates the highest urgency wins. On equal urgency the lower source index wins, and the external input loses to any internal source.
- R9: The outputs show the winner one clock edge after the inputs and registers that produce it.
- R10: With no candidate, `irq_pend` is 0 and both `irq_level` and `irq_code` are 0.
- R11: Writes to addresses 5 to 7 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| src_req | input | 16 | Level-sensitive peripheral requests, bit = source index |
| ext_lvl | input | 4 | Encoded external level, 15 = idle |
| irq_pend | output | 1 | A request is being presented |
| irq_level | output | 4 | Urgency of the presented request |
| irq_code | output | 12 | Event code of the presented request |

## Verification
The bench sweeps every source alone, every external level, and every urgency of one source against every external level. It also sweeps every pair of sources under priorities full of ties. A design that broke ties toward the higher index, or let the external input win a tie, would present the wrong code in those sweeps. Grouped sources are driven one at a time to catch shared or swapped codes. Zero fields and set mask bits are driven with the source pending, so a design that ignored either would raise `irq_pend`. Writes to the unused addresses are followed by readback, so a design that aliased them onto live registers would show changed data.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NSRC    = 16;
    localparam int PRIO_W  = 4;
    localparam int CODE_W  = 12;
    localparam int NPRIO   = 3;
    localparam int FIELDS  = 4;
    localparam int REG_W   = PRIO_W * FIELDS;
    localparam int NGATED  = 7;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ASSERT = 1'b1
    } pic_state_e;

    function automatic logic [CODE_W-1:0] src_code(input int i);
        case (i)
            0:  return 12'h400;
            1:  return 12'h420;
            2:  return 12'h440;
            3:  return 12'h460;
            4:  return 12'h560;
            5:  return 12'h4E0;
            6:  return 12'h500;
            7:  return 12'h520;
            8:  return 12'h540;
            9:  return 12'hB00;
            10: return 12'hB80;
            11: return 12'hA00;
            12: return 12'hA80;
            13: return 12'hA60;
            14: return 12'hA40;
            default: return 12'hA20;
        endcase
    endfunction

    function automatic int src_reg(input int i);
        if (i <= 4)      return 0;
        else if (i <= 8) return 1;
        else             return 2;
    endfunction

    function automatic int src_field(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2, 3: return 2;
            4: return 3;
            5, 6, 7, 8: return 0;
            9, 10: return 0;
            11: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int src_mask_bit(input int i);
        if (i >= 9) return i - 9;
        else        return -1;
    endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int MASK_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NPRIO-1:0][REG_W-1:0]  prio_q,
    output logic [MASK_W-1:0]            mask_q
);

    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(NPRIO);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(NPRIO + 1);

    for (genvar r = 0; r < NPRIO; r++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[r] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(r))
                prio_q[r] <= wr_data[REG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en && wr_addr == A_MSET)
            mask_q <= mask_q | wr_data[MASK_W-1:0];
        else if (wr_en && wr_addr == A_MCLR)
            mask_q <= mask_q & ~wr_data[MASK_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NPRIO))
            rd_data = DATA_W'(prio_q[rd_addr[1:0]]);
        else if (rd_addr == A_MSET || rd_addr == A_MCLR)
            rd_data = DATA_W'(mask_q);
    end

    // R7: set address forces the written ones into the mask
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSET) |=> ((mask_q & $past(wr_data[MASK_W-1:0])) == $past(wr_data[MASK_W-1:0])));

    // R7: clear address removes the written ones from the mask
    a_r7_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MCLR) |=> ((mask_q & $past(wr_data[MASK_W-1:0])) == '0));

    // R2: priority register 0 takes the low half of the written word
    a_r2_prio_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (prio_q[0] == $past(wr_data[REG_W-1:0])));

    // R11: unused addresses leave the mask untouched
    a_r11_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_MCLR) |=> $stable(mask_q));

endmodule

// File: rtl/pic_ext_decode.sv
module pic_ext_decode
    import pic_pkg::*;
(
    input  logic [PRIO_W-1:0] ext_lvl,
    output logic              ext_valid,
    output logic [PRIO_W-1:0] ext_prio,
    output logic [CODE_W-1:0] ext_code
);

    localparam logic [CODE_W-1:0] EXT_BASE = 12'h200;
    localparam int                STEP_SH  = 5;

    always_comb begin
        ext_valid = (ext_lvl != '1);
        ext_prio  = '1 - ext_lvl;
        ext_code  = EXT_BASE + (CODE_W'(ext_lvl) << STEP_SH);
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic [NSRC-1:0]             src_req,
    input  logic [NPRIO-1:0][REG_W-1:0] prio_q,
    input  logic [MASK_W-1:0]           mask_q,
    input  logic                        ext_valid,
    input  logic [PRIO_W-1:0]           ext_prio,
    input  logic [CODE_W-1:0]           ext_code,
    output logic                        win_valid,
    output logic [PRIO_W-1:0]           win_prio,
    output logic [CODE_W-1:0]           win_code
);

    logic [NSRC-1:0][PRIO_W-1:0] src_prio;
    logic [NSRC-1:0][CODE_W-1:0] src_cd;
    logic [NSRC-1:0]             src_gate;
    logic                        unused_mask;

    assign unused_mask = ^mask_q[MASK_W-1:NGATED];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int R  = src_reg(i);
        localparam int F  = src_field(i);
        localparam int MB = src_mask_bit(i);
        assign src_prio[i] = prio_q[R][F*PRIO_W +: PRIO_W];
        assign src_cd[i]   = src_code(i);
        if (MB >= 0) begin : g_gated
            assign src_gate[i] = mask_q[MB];
        end else begin : g_open
            assign src_gate[i] = 1'b0;
        end
    end

    always_comb begin
        win_prio = '0;
        win_code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_req[i] && !src_gate[i] && src_prio[i] > win_prio) begin
                win_prio = src_prio[i];
                win_code = src_cd[i];
            end
        end
        if (ext_valid && ext_prio > win_prio) begin
            win_prio = ext_prio;
            win_code = ext_code;
        end
        win_valid = (win_prio != '0);
    end

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   src_req,
    input  logic [PRIO_W-1:0] ext_lvl,
    output logic              irq_pend,
    output logic [PRIO_W-1:0] irq_level,
    output logic [CODE_W-1:0] irq_code
);

    logic [NPRIO-1:0][REG_W-1:0] prio_q;
    logic [MASK_W-1:0]           mask_q;
    logic                        ext_valid;
    logic [PRIO_W-1:0]           ext_prio;
    logic [CODE_W-1:0]           ext_code;
    logic                        win_valid;
    logic [PRIO_W-1:0]           win_prio;
    logic [CODE_W-1:0]           win_code;
    pic_state_e                  state_q, state_d;

    pic_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .prio_q  (prio_q),
        .mask_q  (mask_q)
    );

    pic_ext_decode u_ext (
        .ext_lvl   (ext_lvl),
        .ext_valid (ext_valid),
        .ext_prio  (ext_prio),
        .ext_code  (ext_code)
    );

    pic_arbiter #(.MASK_W(MASK_W)) u_arb (
        .src_req   (src_req),
        .prio_q    (prio_q),
        .mask_q    (mask_q),
        .ext_valid (ext_valid),
        .ext_prio  (ext_prio),
        .ext_code  (ext_code),
        .win_valid (win_valid),
        .win_prio  (win_prio),
        .win_code  (win_code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid)  state_d = ST_ASSERT;
            ST_ASSERT: if (!win_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= '0;
            irq_code  <= '0;
        end else begin
            unique case (state_d)
                ST_ASSERT: begin
                    irq_level <= win_prio;
                    irq_code  <= win_code;
                end
                default: begin
                    irq_level <= '0;
                    irq_code  <= '0;
                end
            endcase
        end
    end

    assign irq_pend = (state_q == ST_ASSERT);

    // R10: nothing requested at the ports means nothing presented next cycle
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0 && ext_lvl == '1) |=> (!irq_pend && irq_code == '0 && irq_level == '0));

    // R6: external input alone is presented with its computed code and urgency
    a_r6_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0 && ext_lvl != '1) |=>
        (irq_pend && irq_code == 12'h200 + 12'($past(ext_lvl)) * 12'h20
                  && irq_level == 4'hF - $past(ext_lvl)));

    // R3: with every field zero only the external input can be presented
    a_r3_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == '0 && ext_lvl == '1) |=> !irq_pend);

    // R10: an idle presentation always carries zero level and code
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend |-> (irq_level == '0 && irq_code == '0));

endmodule

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] src_req = '0;
    logic [3:0]  ext_lvl = 4'hF;
    logic        irq_pend;
    logic [3:0]  irq_level;
    logic [11:0] irq_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] pa, pb, pc;
    logic [31:0] msk;

    always #2.5 clk = ~clk;

    pic_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_req(src_req), .ext_lvl(ext_lvl), .irq_pend(irq_pend),
        .irq_level(irq_level), .irq_code(irq_code)
    );

    function automatic logic [11:0] m_code(input int i);
        logic [11:0] t [16] = '{12'h400, 12'h420, 12'h440, 12'h460, 12'h560,
                                12'h4E0, 12'h500, 12'h520, 12'h540, 12'hB00,
                                12'hB80, 12'hA00, 12'hA80, 12'hA60, 12'hA40, 12'hA20};
        return t[i];
    endfunction

    function automatic logic [3:0] m_prio(input int i);
        if (i < 2)        return pa[4*i +: 4];
        else if (i < 4)   return pa[11:8];
        else if (i == 4)  return pa[15:12];
        else if (i < 9)   return pb[3:0];
        else if (i < 11)  return pc[3:0];
        else if (i == 11) return pc[7:4];
        else              return pc[11:8];
    endfunction

    // expected {level, code}; level 0 means nothing presented
    function automatic logic [15:0] model(input logic [15:0] req, input logic [3:0] ext);
        logic [3:0]  bl = 0;
        logic [11:0] bc = 0;
        for (int i = 0; i < 16; i++) begin
            if (req[i] && !(i >= 9 && msk[i-9]) && m_prio(i) > bl) begin
                bl = m_prio(i);
                bc = m_code(i);
            end
        end
        if (ext != 4'hF && (4'd15 - ext) > bl) begin
            bl = 4'd15 - ext;
            bc = 12'h200 + 12'(ext) * 12'h20;
        end
        return {bl, bc};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == 0) pa = d[15:0];
        if (a == 1) pb = d[15:0];
        if (a == 2) pc = d[15:0];
        if (a == 3) msk = msk | d;
        if (a == 4) msk = msk & ~d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic drive_out(input string tag, input logic [15:0] req, input logic [3:0] ext);
        logic [15:0] e;
        @(negedge clk);
        src_req = req; ext_lvl = ext;
        @(posedge clk);
        @(negedge clk);
        e = model(req, ext);
        chk(tag, {15'd0, irq_pend, irq_level, irq_code}, {15'd0, e[15:12] != 0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        pa = 0; pb = 0; pc = 0; msk = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", {irq_pend, irq_level, irq_code}, 17'd0);
        rchk("R1 prio0", 3'd0, 32'd0);
        rchk("R1 prio2", 3'd2, 32'd0);
        rchk("R1 mask", 3'd3, 32'hFFFF_FFFF);

        // R2 register load and readback, upper half dropped
        wreg(3'd0, 32'hABCD_1234); rchk("R2 prio0", 3'd0, 32'h0000_1234);
        wreg(3'd1, 32'h0000_F0E1); rchk("R2 prio1", 3'd1, 32'h0000_F0E1);
        wreg(3'd2, 32'h5555_9876); rchk("R2 prio2", 3'd2, 32'h0000_9876);

        // R11 unused addresses
        for (int a = 5; a < 8; a++) begin
            wreg(3'(a), 32'hFFFF_FFFF);
            rchk("R11 read zero", 3'(a), 32'd0);
        end
        rchk("R11 prio0 intact", 3'd0, 32'h0000_1234);
        rchk("R11 mask intact", 3'd4, 32'hFFFF_FFFF);

        // R7 set/clear semantics
        wreg(3'd4, 32'hFFFF_FFFF); rchk("R7 clear all", 3'd3, 32'd0);
        wreg(3'd3, 32'h0000_0005); rchk("R7 set", 3'd4, 32'h5);
        wreg(3'd4, 32'h0000_0001); rchk("R7 clear one", 3'd3, 32'h4);
        wreg(3'd4, 32'hFFFF_FFFF);

        // R4 R5 each source alone with distinct priorities
        wreg(3'd0, 32'h4321); wreg(3'd1, 32'h0005); wreg(3'd2, 32'h0876);
        for (int i = 0; i < 16; i++)
            drive_out($sformatf("R4 R5 source %0d", i), 16'(1) << i, 4'hF);

        // R7 mask gating each gated source
        for (int b = 0; b < 7; b++) begin
            wreg(3'd3, 32'(1) << b);
            drive_out($sformatf("R7 masked bit %0d", b), 16'(1) << (b + 9), 4'hF);
            wreg(3'd4, 32'(1) << b);
        end

        // R3 zero field disables
        wreg(3'd0, 32'h0000);
        drive_out("R3 zero field", 16'h001F, 4'hF);
        wreg(3'd2, 32'h0806);
        drive_out("R3 zero field grp", 16'h0800, 4'hF);

        // R10 idle
        drive_out("R10 no request", 16'h0000, 4'hF);

        // R6 external levels
        for (int n = 0; n < 16; n++)
            drive_out($sformatf("R6 ext %0d", n), 16'h0000, 4'(n));

        // R9 latency: output still old just after inputs change
        drive_out("R9 baseline", 16'h0000, 4'hF);
        @(negedge clk);
        src_req = 16'h0000; ext_lvl = 4'd3;
        #0.5;
        chk("R9 not yet", {15'd0, irq_pend}, 32'd0);
        @(posedge clk); #0.5;
        chk("R9 after edge", {15'd0, irq_pend, irq_code}, {15'd0, 1'b1, 12'h260});

        // R8 urgency of source 0 against every external level
        for (int p = 0; p < 16; p++) begin
            wreg(3'd0, 32'(p));
            for (int n = 0; n < 16; n++)
                drive_out($sformatf("R8 p%0d ext%0d", p, n), 16'h0001, 4'(n));
        end

        // R8 all pairs with many ties
        wreg(3'd0, 32'h3353); wreg(3'd1, 32'h0005); wreg(3'd2, 32'h0535);
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                drive_out($sformatf("R8 pair %0d %0d", i, j), (16'(1) << i) | (16'(1) << j), 4'd12);

        drive_out("R10 back idle", 16'h0000, 4'hF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule